// File: doc/BRIEF.md
# 8-bit Accumulator Processor Core

A small processor core with one shared memory port. It has an 8-bit accumulator A, an 8-bit index register X, and a 10-bit program counter. A 10-bit effective-address register holds the data address, and a 6-bit stack pointer addresses a 64-byte stack. A multi-cycle state machine sequences every instruction. Each cycle it performs exactly one byte access on the bus: an instruction fetch, a data read or write, or a stack transfer. The core expects memory to return read data in the same cycle the address is presented.

Instructions come in two lengths. An instruction that carries an address or a constant takes two bytes: a 6-bit opcode followed by a 10-bit field. Stack, index-step and return instructions take one byte. The core supports the immediate, absolute and absolute-plus-X modes, and the operations add, subtract, compare and NOR. It also has push and pull of A and X, jump, call, return and four conditional branches on the carry and zero flags.

The memory bus has no handshake: every access completes in the cycle it is issued. For that reason the port uses plain strobes rather than valid/ready.

Top module: `acc8_core`

## Requirements
- R1: While rst_n is low, the core forces PC to 0, SP to 63, and the C and Z flags to 0. In the first cycle after release it fetches from address 0 with mem_rd high.
- R2: In every cycle out of reset exactly one of mem_rd and mem_wr is high. Instruction bytes are read one per cycle from consecutive addresses starting at PC.
- R3: A two-byte instruction is laid out as first byte {opcode[5:0], field[9:8]} and second byte field[7:0]. A one-byte instruction is {opcode[5:0], 2'b00}. Opcodes (hex): 00 NOP, 01 PHA, 02 PLA, 03 PHX, 04 PLX, 05 INX, 06 DEX, 07 RET, 20/21/22 LDA imm/abs/absX, 23/24 STA abs/absX, 25/26 LDX imm/abs, 27 STX abs, 28/29/2A ADD imm/abs/absX, 2B/2C/2D SUB imm/abs/absX, 2E/2F CMP imm/abs, 30/31 NOR imm/abs, 32 JMP, 33 CALL, 34 BCS, 35 BZS, 36 BCC, 37 BZC.
- R4: Immediate forms use field[7:0] as the operand. Absolute forms read or write memory at field. LDA, LDX, STA and STX move bytes between memory and A or X.
- R5: The absolute-plus-X address is (field + X) mod 1024.
- R6: ADD sets A to (A + M) mod 256 and C to the carry-out, with no carry-in. Z is set when the 8-bit result is zero. ADD #0 therefore clears C.
- R7: SUB sets A to (A - M) mod 256 and C to 1 when A >= M (no borrow). SUB #0 therefore sets C. CMP sets C and Z the same way but leaves A unchanged. NOR sets A to ~(A | M), sets Z from the result and leaves C unchanged.
- R8: INX and DEX step X by +1 or -1 mod 256 and set Z from the new X. Loads, stores, stack operations, NOP, jumps, calls and branches leave C and Z unchanged.
- R9: A push writes to address 0x3C0 + SP and then decrements SP. A pull first increments SP and then reads 0x3C0 + SP. PHA/PLA move A, and PHX/PLX move X.
- R10: CALL pushes the address of the next instruction, first its high byte (bits 9:8, zero-extended) and then its low byte, and then jumps to field. RET pulls the low byte, then the high byte, and resumes there.
- R11: JMP always loads PC with field. BCS, BZS, BCC and BZC load PC with field when C=1, Z=1, C=0 and Z=0 respectively. Otherwise execution continues with the next instruction.
- R12: An opcode that is not in the table acts as a one-byte no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 10 | Byte address of this cycle's access |
| mem_rdata | input | 8 | Read data, valid in the same cycle as mem_rd |
| mem_wdata | output | 8 | Write data, valid while mem_wr is high |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
All internal state becomes visible only through bus traffic. A wrong PC appears on mem_addr at the next fetch cycle. A wrong SP appears as a stack write or read outside the expected 0x3C0-based slot at the very next push, pull, call or return. A corrupted A, X or flag stays hidden until a store writes it out, or until a branch fetches from the wrong address. The test programs therefore store each register or turn each flag into a stored marker within a few instructions of the operation under test.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  // Sequencer states
  typedef enum logic [3:0] {
    S_F0, S_F1, S_MRD, S_MWR, S_PUSH, S_PULL,
    S_CALLH, S_CALLL, S_RETL, S_RETH
  } state_t;

  typedef enum logic [3:0] {
    K_NOP, K_LDA, K_STA, K_LDX, K_STX, K_ALU, K_JMP, K_CALL,
    K_BR, K_PHA, K_PLA, K_PHX, K_PLX, K_INX, K_DEX, K_RET
  } kind_t;

  typedef enum logic [1:0] {AM_IMM, AM_ABS, AM_IDX} amode_t;
  typedef enum logic [1:0] {AL_ADD, AL_SUB, AL_CMP, AL_NOR} aluop_t;
  typedef enum logic [1:0] {BR_CS, BR_ZS, BR_CC, BR_ZC} brc_t;

  typedef struct packed {
    kind_t  kind;
    amode_t mode;
    aluop_t alu;
    brc_t   br;
    logic   wide;   // instruction carries a second byte
  } dec_t;

  localparam int OPC_W = 6;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
#(
  parameter int OP_W = OPC_W
) (
  input  logic [OP_W-1:0] op,
  output dec_t            d
);

  always_comb begin
    d = '{kind: K_NOP, mode: AM_IMM, alu: AL_ADD, br: BR_CS, wide: 1'b0};
    case (op)
      6'h01: d.kind = K_PHA;
      6'h02: d.kind = K_PLA;
      6'h03: d.kind = K_PHX;
      6'h04: d.kind = K_PLX;
      6'h05: d.kind = K_INX;
      6'h06: d.kind = K_DEX;
      6'h07: d.kind = K_RET;
      6'h20: begin d.kind = K_LDA; d.wide = 1'b1; end
      6'h21: begin d.kind = K_LDA; d.mode = AM_ABS; d.wide = 1'b1; end
      6'h22: begin d.kind = K_LDA; d.mode = AM_IDX; d.wide = 1'b1; end
      6'h23: begin d.kind = K_STA; d.mode = AM_ABS; d.wide = 1'b1; end
      6'h24: begin d.kind = K_STA; d.mode = AM_IDX; d.wide = 1'b1; end
      6'h25: begin d.kind = K_LDX; d.wide = 1'b1; end
      6'h26: begin d.kind = K_LDX; d.mode = AM_ABS; d.wide = 1'b1; end
      6'h27: begin d.kind = K_STX; d.mode = AM_ABS; d.wide = 1'b1; end
      6'h28: begin d.kind = K_ALU; d.alu = AL_ADD; d.wide = 1'b1; end
      6'h29: begin d.kind = K_ALU; d.alu = AL_ADD; d.mode = AM_ABS; d.wide = 1'b1; end
      6'h2A: begin d.kind = K_ALU; d.alu = AL_ADD; d.mode = AM_IDX; d.wide = 1'b1; end
      6'h2B: begin d.kind = K_ALU; d.alu = AL_SUB; d.wide = 1'b1; end
      6'h2C: begin d.kind = K_ALU; d.alu = AL_SUB; d.mode = AM_ABS; d.wide = 1'b1; end
      6'h2D: begin d.kind = K_ALU; d.alu = AL_SUB; d.mode = AM_IDX; d.wide = 1'b1; end
      6'h2E: begin d.kind = K_ALU; d.alu = AL_CMP; d.wide = 1'b1; end
      6'h2F: begin d.kind = K_ALU; d.alu = AL_CMP; d.mode = AM_ABS; d.wide = 1'b1; end
      6'h30: begin d.kind = K_ALU; d.alu = AL_NOR; d.wide = 1'b1; end
      6'h31: begin d.kind = K_ALU; d.alu = AL_NOR; d.mode = AM_ABS; d.wide = 1'b1; end
      6'h32: begin d.kind = K_JMP;  d.wide = 1'b1; end
      6'h33: begin d.kind = K_CALL; d.wide = 1'b1; end
      6'h34: begin d.kind = K_BR; d.br = BR_CS; d.wide = 1'b1; end
      6'h35: begin d.kind = K_BR; d.br = BR_ZS; d.wide = 1'b1; end
      6'h36: begin d.kind = K_BR; d.br = BR_CC; d.wide = 1'b1; end
      6'h37: begin d.kind = K_BR; d.br = BR_ZC; d.wide = 1'b1; end
      default: ;  // R12: unlisted opcodes fall through as a one-byte no-op
    endcase
  end

endmodule

// File: rtl/acc8_alu.sv
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  aluop_t            op,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              carry_we,
  output logic              a_we
);

  logic [DATA_W:0] sum, dif;

  assign sum = {1'b0, a} + {1'b0, b};
  assign dif = {1'b0, a} - {1'b0, b};

  always_comb begin
    res      = sum[DATA_W-1:0];
    carry    = sum[DATA_W];
    carry_we = 1'b1;
    a_we     = 1'b1;
    case (op)
      AL_ADD: ;
      AL_SUB: begin res = dif[DATA_W-1:0]; carry = ~dif[DATA_W]; end
      AL_CMP: begin res = dif[DATA_W-1:0]; carry = ~dif[DATA_W]; a_we = 1'b0; end
      AL_NOR: begin res = ~(a | b); carry = 1'b0; carry_we = 1'b0; end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int SP_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr
);

  localparam int OP_W    = 2*DATA_W - ADDR_W;
  localparam int HI_W    = ADDR_W - DATA_W;
  localparam int STK_PAD = ADDR_W - SP_W;

  state_t            st;
  logic [ADDR_W-1:0] pc, ea;
  logic [DATA_W-1:0] ir, a, x;
  logic [SP_W-1:0]   sp;
  logic              cf, zf;

  logic [DATA_W-1:0] cur;
  dec_t              d;
  logic [ADDR_W-1:0] fld, fld_x, stk_push, stk_pull;
  logic [SP_W-1:0]   sp_up, sp_dn;
  logic [DATA_W-1:0] x_inc, x_dec, alu_res;
  logic              alu_c, alu_cwe, alu_awe, take;

  // In the first fetch cycle the opcode is decoded straight off the bus
  assign cur = (st == S_F0) ? mem_rdata : ir;

  acc8_decode #(.OP_W(OP_W)) u_dec (
    .op (cur[DATA_W-1 -: OP_W]),
    .d  (d)
  );

  acc8_alu #(.DATA_W(DATA_W)) u_alu (
    .a        (a),
    .b        (mem_rdata),
    .op       (d.alu),
    .res      (alu_res),
    .carry    (alu_c),
    .carry_we (alu_cwe),
    .a_we     (alu_awe)
  );

  assign fld      = {ir[HI_W-1:0], mem_rdata};
  assign fld_x    = fld + {{HI_W{1'b0}}, x};
  assign sp_up    = sp + 1'b1;
  assign sp_dn    = sp - 1'b1;
  assign stk_push = {{STK_PAD{1'b1}}, sp};
  assign stk_pull = {{STK_PAD{1'b1}}, sp_up};
  assign x_inc    = x + 1'b1;
  assign x_dec    = x - 1'b1;

  always_comb begin
    case (d.br)
      BR_CS:   take = cf;
      BR_ZS:   take = zf;
      BR_CC:   take = ~cf;
      default: take = ~zf;
    endcase
  end

  // Bus drive: exactly one access per state
  always_comb begin
    mem_addr  = pc;
    mem_wdata = a;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    case (st)
      S_F0, S_F1: mem_rd = 1'b1;
      S_MRD: begin mem_rd = 1'b1; mem_addr = ea; end
      S_MWR: begin
        mem_wr    = 1'b1;
        mem_addr  = ea;
        mem_wdata = (d.kind == K_STX) ? x : a;
      end
      S_PUSH: begin
        mem_wr    = 1'b1;
        mem_addr  = stk_push;
        mem_wdata = (d.kind == K_PHX) ? x : a;
      end
      S_PULL, S_RETL, S_RETH: begin mem_rd = 1'b1; mem_addr = stk_pull; end
      S_CALLH: begin
        mem_wr    = 1'b1;
        mem_addr  = stk_push;
        mem_wdata = {{(DATA_W-HI_W){1'b0}}, pc[ADDR_W-1:DATA_W]};
      end
      S_CALLL: begin
        mem_wr    = 1'b1;
        mem_addr  = stk_push;
        mem_wdata = pc[DATA_W-1:0];
      end
      default: mem_rd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_F0;
      pc <= '0;
      ea <= '0;
      ir <= '0;
      a  <= '0;
      x  <= '0;
      sp <= '1;
      cf <= 1'b0;
      zf <= 1'b0;
    end else begin
      case (st)
        S_F0: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
          st <= S_F0;
          if (d.wide) st <= S_F1;
          case (d.kind)
            K_INX: begin x <= x_inc; zf <= (x_inc == '0); end
            K_DEX: begin x <= x_dec; zf <= (x_dec == '0); end
            K_PHA, K_PHX: st <= S_PUSH;
            K_PLA, K_PLX: st <= S_PULL;
            K_RET:        st <= S_RETL;
            default: ;
          endcase
        end
        S_F1: begin
          pc <= pc + 1'b1;
          ea <= (d.mode == AM_IDX) ? fld_x : fld;
          st <= S_F0;
          case (d.kind)
            K_LDA: if (d.mode == AM_IMM) a <= mem_rdata; else st <= S_MRD;
            K_LDX: if (d.mode == AM_IMM) x <= mem_rdata; else st <= S_MRD;
            K_STA, K_STX: st <= S_MWR;
            K_ALU: begin
              if (d.mode == AM_IMM) begin
                if (alu_awe) a <= alu_res;
                if (alu_cwe) cf <= alu_c;
                zf <= (alu_res == '0);
              end else begin
                st <= S_MRD;
              end
            end
            K_JMP:  pc <= fld;
            K_CALL: st <= S_CALLH;
            K_BR:   if (take) pc <= fld;
            default: ;
          endcase
        end
        S_MRD: begin
          st <= S_F0;
          case (d.kind)
            K_LDA: a <= mem_rdata;
            K_LDX: x <= mem_rdata;
            K_ALU: begin
              if (alu_awe) a <= alu_res;
              if (alu_cwe) cf <= alu_c;
              zf <= (alu_res == '0);
            end
            default: ;
          endcase
        end
        S_MWR: st <= S_F0;
        S_PUSH: begin sp <= sp_dn; st <= S_F0; end
        S_PULL: begin
          sp <= sp_up;
          if (d.kind == K_PLX) x <= mem_rdata; else a <= mem_rdata;
          st <= S_F0;
        end
        S_CALLH: begin sp <= sp_dn; st <= S_CALLL; end
        S_CALLL: begin sp <= sp_dn; pc <= ea; st <= S_F0; end
        S_RETL: begin
          sp <= sp_up;
          ea[DATA_W-1:0] <= mem_rdata;
          st <= S_RETH;
        end
        S_RETH: begin
          sp <= sp_up;
          pc <= {mem_rdata[HI_W-1:0], ea[DATA_W-1:0]};
          st <= S_F0;
        end
        default: st <= S_F0;
      endcase
    end
  end

endmodule

// File: rtl/acc8_chk.sv
module acc8_chk
  import acc8_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int SP_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input state_t            st,
  input logic              cf,
  input logic              zf
);

  localparam int HI_W = ADDR_W - DATA_W;

  // R2
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr}) == 1);

  // R3
  operand_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F1) |-> (mem_rd && mem_addr == $past(mem_addr) + 1'b1));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MWR || st == S_PUSH || st == S_PULL || st == S_CALLH ||
     st == S_CALLL || st == S_RETL || st == S_RETH)
    |=> ($stable(cf) && $stable(zf)));

  // R9
  stack_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PUSH || st == S_PULL || st == S_RETL || st == S_RETH)
    |-> (&mem_addr[ADDR_W-1:SP_W]));

  // R10
  call_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CALLH) |-> (mem_wr && (&mem_addr[ADDR_W-1:SP_W]) &&
                         mem_wdata[DATA_W-1:HI_W] == '0));

  // R10
  call_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CALLL) |-> (mem_wr && mem_addr + 1'b1 == $past(mem_addr)));

endmodule

bind acc8_core acc8_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .st        (st),
  .cf        (cf),
  .zf        (zf)
);

// File: tb/sim_acc8_core.sv
`timescale 1ns/1ps
module sim_acc8_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] mem_addr;
  logic [7:0] mem_rdata, mem_wdata;
  logic       mem_rd, mem_wr;

  logic [7:0] mem [0:1023];
  int ptr = 0;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  acc8_core u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  // Opcodes (R3)
  localparam logic [5:0] NOP = 6'h00, PHA = 6'h01, PLA = 6'h02, PHX = 6'h03,
    PLX = 6'h04, INX = 6'h05, DEX = 6'h06, RET = 6'h07,
    LDAI = 6'h20, LDAA = 6'h21, LDAX = 6'h22, STAA = 6'h23,
    LDXI = 6'h25, STXA = 6'h27, ADDI = 6'h28, ADDX = 6'h2A,
    SUBI = 6'h2B, CMPI = 6'h2E, NORI = 6'h30,
    JMP = 6'h32, CALL = 6'h33, BCS = 6'h34, BZS = 6'h35, BCC = 6'h36, BZC = 6'h37;

  // {alu sel, A, operand, result, C, Z}; sel 0 ADD, 1 SUB, 2 CMP, 3 NOR
  localparam logic [27:0] VEC [14] = '{
    {2'd0, 8'h10, 8'h20, 8'h30, 1'b0, 1'b0},
    {2'd0, 8'hF0, 8'h20, 8'h10, 1'b1, 1'b0},
    {2'd0, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1},
    {2'd0, 8'h55, 8'h00, 8'h55, 1'b0, 1'b0},
    {2'd1, 8'h30, 8'h10, 8'h20, 1'b1, 1'b0},
    {2'd1, 8'h10, 8'h30, 8'hE0, 1'b0, 1'b0},
    {2'd1, 8'h42, 8'h42, 8'h00, 1'b1, 1'b1},
    {2'd1, 8'h07, 8'h00, 8'h07, 1'b1, 1'b0},
    {2'd2, 8'h42, 8'h42, 8'h42, 1'b1, 1'b1},
    {2'd2, 8'h10, 8'h20, 8'h10, 1'b0, 1'b0},
    {2'd2, 8'h20, 8'h10, 8'h20, 1'b1, 1'b0},
    {2'd3, 8'h0F, 8'hF0, 8'h00, 1'b0, 1'b1},
    {2'd3, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0},
    {2'd3, 8'hA5, 8'h7F, 8'h00, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    ptr = 0;
  endtask

  task automatic put2(input logic [5:0] op, input logic [9:0] v);
    mem[ptr]   = {op, v[9:8]};
    mem[ptr+1] = v[7:0];
    ptr += 2;
  endtask

  task automatic put1(input logic [5:0] op);
    mem[ptr] = {op, 2'b00};
    ptr += 1;
  endtask

  task automatic release_rst();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // ---- Table walk: ALU ops with flag markers ----
    for (int v = 0; v < 14; v++) begin
      logic [1:0] sel;
      logic [5:0] aop;
      sel = VEC[v][27:26];
      case (sel)
        2'd0: aop = ADDI;
        2'd1: aop = SUBI;
        2'd2: aop = CMPI;
        default: aop = NORI;
      endcase
      clear_mem();
      put2(LDAI, {2'b00, VEC[v][25:18]});     // 0
      put2(aop,  {2'b00, VEC[v][17:10]});     // 2
      put2(STAA, 10'h200);                    // 4
      put2(LDXI, 10'h000);                    // 6
      put2(BCC,  10'd12);                     // 8
      put2(LDXI, 10'h001);                    // 10
      put2(STXA, 10'h201);                    // 12
      put2(LDXI, 10'h000);                    // 14
      put2(BZC,  10'd20);                     // 16
      put2(LDXI, 10'h001);                    // 18
      put2(STXA, 10'h202);                    // 20
      put2(JMP,  10'd22);                     // 22
      release_rst();
      run(80);
      // R6 R7 result; R8 loads/stores between op and branch keep flags
      chk($sformatf("R6/R7 result vec %0d", v), {2'b00, mem[10'h200]}, {2'b00, VEC[v][9:2]});
      chk($sformatf("R6/R7 carry vec %0d (R11 BCC, R8)", v), {2'b00, mem[10'h201]}, {9'd0, VEC[v][1]});
      chk($sformatf("R6/R7 zero vec %0d (R11 BZC, R8)", v), {2'b00, mem[10'h202]}, {9'd0, VEC[v][0]});
    end

    // ---- Reset, fetch order, indexed addressing, INX/DEX ----
    clear_mem();
    mem[10'h150] = 8'h33;
    mem[10'h155] = 8'h44;
    put2(LDXI, 10'h005);                      // 0
    put2(LDAX, 10'h150);                      // 2
    put2(STAA, 10'h300);                      // 4
    put2(LDAA, 10'h150);                      // 6
    put2(ADDX, 10'h150);                      // 8
    put2(STAA, 10'h301);                      // 10
    put1(INX); put1(INX);                     // 12,13
    put2(STXA, 10'h302);                      // 14
    for (int k = 0; k < 7; k++) put1(DEX);    // 16..22
    put2(BZS,  10'd28);                       // 23
    put2(LDXI, 10'h0EE);                      // 25
    put1(NOP);                                // 27
    put2(STXA, 10'h303);                      // 28
    put2(LDXI, 10'h020);                      // 30
    put2(LDAX, 10'h3F0);                      // 32
    put2(STAA, 10'h304);                      // 34
    put2(JMP,  10'd36);                       // 36
    release_rst();
    #1;
    chk("R1 first fetch address", mem_addr, 10'h000);
    chk("R1 read strobe after reset", {9'd0, mem_rd}, 10'd1);
    chk("R2 no write at reset", {9'd0, mem_wr}, 10'd0);
    @(negedge clk);
    chk("R3 operand byte fetched next", mem_addr, 10'h001);
    run(100);
    chk("R5 LDA abs,X", {2'b00, mem[10'h300]}, 10'h044);
    chk("R4 ADD abs,X after LDA abs", {2'b00, mem[10'h301]}, 10'h077);
    chk("R8 INX twice", {2'b00, mem[10'h302]}, 10'h007);
    chk("R8 DEX sets Z (R11 BZS taken)", {2'b00, mem[10'h303]}, 10'h000);
    chk("R5 index wraps mod 1024", {2'b00, mem[10'h304]}, {2'b00, DEX, 2'b00});

    // ---- BCS / BZS after SUB equal ----
    clear_mem();
    put2(LDAI, 10'h001);                      // 0
    put2(SUBI, 10'h001);                      // 2
    put2(BCS,  10'd8);                        // 4
    put2(LDAI, 10'h0EE);                      // 6
    put2(BZS,  10'd12);                       // 8
    put2(LDAI, 10'h0DD);                      // 10
    put2(STAA, 10'h330);                      // 12
    put2(JMP,  10'd14);                       // 14
    release_rst();
    run(60);
    chk("R11 BCS and BZS taken", {2'b00, mem[10'h330]}, 10'h000);

    // ---- Stack push/pull ----
    clear_mem();
    put2(LDAI, 10'h011);                      // 0
    put1(PHA);                                // 2
    put2(LDAI, 10'h022);                      // 3
    put1(PHA);                                // 5
    put2(LDXI, 10'h033);                      // 6
    put1(PHX);                                // 8
    put1(PLA);                                // 9
    put1(PLX);                                // 10
    put2(STAA, 10'h310);                      // 11
    put2(STXA, 10'h311);                      // 13
    put1(PLA);                                // 15
    put2(STAA, 10'h312);                      // 16
    put2(JMP,  10'd18);                       // 18
    release_rst();
    run(80);
    chk("R1 SP starts at top (first push at 0x3FF)", {2'b00, mem[10'h3FF]}, 10'h011);
    chk("R9 push post-decrement", {2'b00, mem[10'h3FE]}, 10'h022);
    chk("R9 PHX writes X", {2'b00, mem[10'h3FD]}, 10'h033);
    chk("R9 PLA pulls last push", {2'b00, mem[10'h310]}, 10'h033);
    chk("R9 PLX pulls next", {2'b00, mem[10'h311]}, 10'h022);
    chk("R9 PLA pulls oldest", {2'b00, mem[10'h312]}, 10'h011);

    // ---- Call / return ----
    clear_mem();
    put2(JMP, 10'h140);
    ptr = 10'h140;
    put2(CALL, 10'h080);
    put2(LDAI, 10'h099);
    put2(STAA, 10'h320);
    put2(JMP,  10'h146);
    ptr = 10'h080;
    put2(LDAI, 10'h05A);
    put2(STAA, 10'h321);
    put1(RET);
    release_rst();
    run(80);
    chk("R10 return high byte pushed first", {2'b00, mem[10'h3FF]}, 10'h001);
    chk("R10 return low byte", {2'b00, mem[10'h3FE]}, 10'h042);
    chk("R10 subroutine ran", {2'b00, mem[10'h321]}, 10'h05A);
    chk("R10 RET resumes after CALL", {2'b00, mem[10'h320]}, 10'h099);
    chk("R11 JMP loop holds PC", mem_addr >= 10'h146 && mem_addr <= 10'h147 ? 10'd1 : 10'd0, 10'd1);

    // ---- Unknown opcodes ----
    clear_mem();
    put2(LDAI, 10'h012);                      // 0
    put1(6'h0F);                              // 2
    put1(6'h3F);                              // 3
    put2(STAA, 10'h340);                      // 4
    put2(JMP,  10'd6);                        // 6
    release_rst();
    run(40);
    chk("R12 unknown opcodes are one-byte no-ops", {2'b00, mem[10'h340]}, 10'h012);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule